// File: doc/BRIEF.md
# Run-Triggered Bit Inversion Filter

This block is a serial filter that takes one bit per clock and returns one bit per clock. It runs in one of two modes. In pass mode the output bit equals the input bit. In invert mode the output bit is the complement of the input bit.

The mode changes when the input shows a run of two equal bits. A pair of zeros moves the filter from pass to invert. Only a pair of ones moves it back. The bit that completes a pair is still handled under the old mode, and the new mode takes effect from the following bit.

The output is a Mealy function of the current state and the current input bit, so it responds in the same cycle as the input. The state is held in two JK-style flip-flops. A valid qualifier marks which cycles carry data. In idle cycles the state holds and the output is driven low.

Top module: `run_flip_filter`

## Requirements
- R1: A synchronous active-high reset returns the filter to pass mode and clears any pending half of a pair. A single zero seen before reset does not combine with a zero seen after it.
- R2: In pass mode, `dout` equals `din` in the same cycle whenever `din_vld` is 1.
- R3: In pass mode, two valid zeros in a row switch the filter to invert mode. The second zero is output as 0, and inversion applies from the next valid bit onward.
- R4: In invert mode, `dout` equals the complement of `din` in the same cycle whenever `din_vld` is 1.
- R5: In invert mode, two valid ones in a row switch the filter back to pass mode. The second one is output as 0, and pass-through applies from the next valid bit onward.
- R6: A single zero followed by a one in pass mode cancels the pending zero. A single one followed by a zero in invert mode cancels the pending one.
- R7: Runs overlap only up to the mode switch. In the input 0 0 0, the third zero is already inverted (output 1). In the input 0 0 1 1, the two ones return the filter to pass mode.
- R8: When `din_vld` is 0, `dout` is 0 and the state is unchanged. Bits on either side of an idle gap still form a pair.
- R9: The input stream 10110001001011011, applied first bit first, yields the output 10110010110100011.
- R10: The state takes four values held in two bits: 00 = pass with no pending zero, 01 = pass after one zero, 10 = invert with no pending one, 11 = invert after one one. Each bit is updated through J/K excitation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din_vld | input | 1 | High when `din` carries a data bit this cycle |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output, combinational from the state and `din` |

## Verification
The filter has no size parameters, so the bench builds it in its only configuration, with a two-bit state. This one build reaches every state-and-input pair: the fixed example stream, overlapping zero runs, a pair that straddles a mode switch, and idle gaps inside a pending pair. Reset is also applied while a zero is pending. A long random stream with random idle cycles is then compared every cycle against a model that tracks only a mode flag and the previous valid bit.

// File: rtl/run_flip_pkg.sv
package run_flip_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_PASS_IDLE = 2'b00,
    ST_PASS_ZERO = 2'b01,
    ST_INV_IDLE  = 2'b10,
    ST_INV_ONE   = 2'b11
  } flt_state_e;

  localparam int MODE_BIT = 1;
  localparam int PEND_BIT = 0;
endpackage

// File: rtl/jk_cell.sv
module jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end
endmodule

// File: rtl/flip_excite.sv
module flip_excite
  import run_flip_pkg::*;
(
  input  logic               enable,
  input  logic               bit_in,
  input  logic [STATE_W-1:0] cur,
  output logic [STATE_W-1:0] j_vec,
  output logic [STATE_W-1:0] k_vec
);
  logic mode_q;
  logic pend_q;

  assign mode_q = cur[MODE_BIT];
  assign pend_q = cur[PEND_BIT];

  // Minimized excitation; J/K forced low when idle so the state holds.
  always_comb begin
    j_vec = '0;
    k_vec = '0;
    if (enable) begin
      j_vec[MODE_BIT] = pend_q & ~bit_in;
      k_vec[MODE_BIT] = pend_q & bit_in;
      j_vec[PEND_BIT] = ~(mode_q ^ bit_in);
      k_vec[PEND_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/run_flip_filter.sv
module run_flip_filter
  import run_flip_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din_vld,
  input  logic din,
  output logic dout
);
  logic [STATE_W-1:0] st_q;
  logic [STATE_W-1:0] j_vec;
  logic [STATE_W-1:0] k_vec;

  flip_excite u_excite (
    .enable (din_vld),
    .bit_in (din),
    .cur    (st_q),
    .j_vec  (j_vec),
    .k_vec  (k_vec)
  );

  for (genvar g = 0; g < STATE_W; g++) begin : g_ff
    jk_cell u_ff (
      .clk (clk),
      .rst (rst),
      .j   (j_vec[g]),
      .k   (k_vec[g]),
      .q   (st_q[g])
    );
  end

  assign dout = din_vld & (din ^ st_q[MODE_BIT]);

  // R3
  zero_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !din && st_q == ST_PASS_ZERO) |=> st_q == ST_INV_IDLE);

  // R5
  one_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (din_vld && din && st_q == ST_INV_ONE) |=> st_q == ST_PASS_IDLE);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> $stable(st_q));

  // R6
  lone_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (din_vld && st_q == ST_PASS_IDLE) |=> !st_q[MODE_BIT]);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !din_vld |-> !dout);
endmodule

// File: tb/run_flip_filter_bench.sv
module run_flip_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_vld = 1'b0;
  logic din = 1'b0;
  logic dout;

  int n_tests = 0;
  int n_fail = 0;
  bit model_inv = 0;
  bit model_pend = 0;

  run_flip_filter u_run_flip_filter (
    .clk (clk), .rst (rst), .din_vld (din_vld), .din (din), .dout (dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; din_vld = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_inv = 0; model_pend = 0;
  endtask

  // Drive one cycle, compare with the model, then advance the model.
  task automatic step(input bit v, input bit b, input string req, output logic got);
    logic exp;
    @(negedge clk);
    din_vld = v; din = b;
    #1;
    exp = v ? (b ^ model_inv) : 1'b0;
    got = dout;
    check(req, got, exp);
    if (v) begin
      if (!model_inv) begin
        if (!b && model_pend) begin model_inv = 1; model_pend = 0; end
        else model_pend = !b;
      end else begin
        if (b && model_pend) begin model_inv = 0; model_pend = 0; end
        else model_pend = b;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic got;
    logic [16:0] ex_in  = 17'b10110001001011011;
    logic [16:0] ex_out = 17'b10110010110100011;

    do_reset();
    // R1: reset state is pass mode
    step(1, 1, "R1", got); check("R1", got, 1'b1);
    step(1, 0, "R1", got); check("R1", got, 1'b0);

    // R2 / R6: 0 1 0 1 in pass must not invert
    do_reset();
    step(1, 0, "R6", got); step(1, 1, "R6", got);
    step(1, 0, "R6", got); step(1, 1, "R2", got); check("R2", got, 1'b1);

    // R3 / R7: 0 0 0 -> third is inverted
    do_reset();
    step(1, 0, "R3", got); step(1, 0, "R3", got); check("R3", got, 1'b0);
    step(1, 0, "R7", got); check("R7", got, 1'b1);
    // R4: invert mode complements
    step(1, 1, "R4", got); check("R4", got, 1'b0);
    step(1, 0, "R6", got); check("R6", got, 1'b1);
    // R5: 1 1 returns to pass, second one output 0
    step(1, 1, "R5", got); step(1, 1, "R5", got); check("R5", got, 1'b0);
    step(1, 1, "R5", got); check("R5", got, 1'b1);

    // R7: 0 0 1 1 spanning the switch, then pass
    do_reset();
    step(1, 0, "R7", got); step(1, 0, "R7", got);
    step(1, 1, "R7", got); check("R7", got, 1'b0);
    step(1, 1, "R7", got); check("R7", got, 1'b0);
    step(1, 0, "R7", got); check("R7", got, 1'b0);

    // R8: idle gap inside a pending pair, output low while idle
    do_reset();
    step(1, 0, "R8", got);
    step(0, 1, "R8", got); check("R8", got, 1'b0);
    step(0, 0, "R8", got); check("R8", got, 1'b0);
    step(1, 0, "R8", got); check("R8", got, 1'b0);
    step(1, 1, "R8", got); check("R8", got, 1'b0);

    // R1: reset clears a pending zero
    do_reset();
    step(1, 0, "R1", got);
    do_reset();
    step(1, 0, "R1", got); step(1, 1, "R1", got); check("R1", got, 1'b1);

    // R9 / R10: worked example walks all state/input pairs
    do_reset();
    for (int i = 16; i >= 0; i--) begin
      step(1, ex_in[i], "R9", got);
      check("R9", got, ex_out[i]);
    end

    // R2 R4 R8: long random stream against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) != 0, $urandom % 2, "R10", got);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule